// File: doc/BRIEF.md
# Source-Selecting Slice ALU

This block is the purely combinational arithmetic and logic core of a wide microprogrammed data path. A 3-bit source code chooses the operand pair (R, S) from the A-port word, the B-port word, the direct data word D, the Q word and a constant zero. A 3-bit function code chooses one of three arithmetic operations or one of five logic operations. The block returns the result word together with carry-out, overflow, sign and zero flags.

The register file, the Q register, the shifters and the output drivers sit around this block. They feed it and take its result, but they are not part of it. The adder structure is chosen by a parameter: a plain ripple chain or 4-bit grouped carry generation. Both structures give the same results.

Top module: `slice_alu`

## Requirements
- R1: The source code selects (R, S) as 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R2: Function code 0 gives result = R + S + carry_in, modulo 2^WIDTH.
- R3: Function code 1 gives S minus R, formed as S + ~R + carry_in. With source 7, carry_in 0 yields -D-1 and carry_in 1 yields -D.
- R4: Function code 2 gives R minus S, formed as R + ~S + carry_in.
- R5: Function codes 3 to 7 give, bitwise, R OR S, R AND S, (NOT R) AND S, R XOR S and R XNOR S.
- R6: For function codes 3 to 7, carry_in has no effect on any output.
- R7: sign equals the most significant bit of the result, not inverted.
- R8: zero is high exactly when every bit of the result is low.
- R9: In arithmetic codes, overflow is high exactly when the carry into the top bit differs from the carry out of it. This is the case where the two adder operands share a sign and the result has the other sign.
- R10: In arithmetic codes, carry_out is the carry leaving the top bit of the adder.
- R11: For function codes 3 to 7, carry_out and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | 3 | Operand pair code |
| fn_sel | input | 3 | Operation code |
| carry_in | input | 1 | Adder carry input |
| a_val | input | WIDTH | A-port word |
| b_val | input | WIDTH | B-port word |
| d_val | input | WIDTH | Direct data word |
| q_val | input | WIDTH | Q word |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the top adder bit |
| overflow | output | 1 | Two's-complement overflow |
| sign | output | 1 | Top bit of the result |
| zero | output | 1 | Result is all zeros |

## Verification
The assertions watch these relations whenever an input changes:
- the flags stay quiet in logic mode;
- a zero result never reports a negative sign;
- overflow only appears when the adder operands share a sign and the result flips it;
- a fully propagating operand pair passes the carry straight through;
- the zero-substituting source codes really present zero.

The correct value of each operation on each operand pair can only be shown by the bench. It uses directed operand patterns, boundary sums at the signed and unsigned limits, both carry-in values, and a pseudo-random sweep compared against an independent model.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

   typedef enum logic [2:0] {
      SRC_A_Q  = 3'd0,
      SRC_A_B  = 3'd1,
      SRC_Z_Q  = 3'd2,
      SRC_Z_B  = 3'd3,
      SRC_Z_A  = 3'd4,
      SRC_D_A  = 3'd5,
      SRC_D_Q  = 3'd6,
      SRC_D_Z  = 3'd7
   } src_sel_e;

   typedef enum logic [2:0] {
      FN_ADD    = 3'd0,
      FN_SUB_SR = 3'd1,
      FN_SUB_RS = 3'd2,
      FN_OR     = 3'd3,
      FN_AND    = 3'd4,
      FN_ANDN   = 3'd5,
      FN_XOR    = 3'd6,
      FN_XNOR   = 3'd7
   } fn_sel_e;

   localparam int ADDER_RIPPLE  = 0;
   localparam int ADDER_GROUPED = 1;

   function automatic logic fn_is_arith(fn_sel_e f);
      return (f == FN_ADD) || (f == FN_SUB_SR) || (f == FN_SUB_RS);
   endfunction

endpackage

// File: rtl/slice_alu_operands.sv
module slice_alu_operands
   import slice_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  src_sel_e         src,
   input  logic [WIDTH-1:0] a_word,
   input  logic [WIDTH-1:0] b_word,
   input  logic [WIDTH-1:0] d_word,
   input  logic [WIDTH-1:0] q_word,
   output logic [WIDTH-1:0] r_op,
   output logic [WIDTH-1:0] s_op
);

   localparam logic [WIDTH-1:0] ZERO_WORD = '0;

   always_comb begin
      unique case (src)
         SRC_A_Q: begin r_op = a_word;    s_op = q_word;    end
         SRC_A_B: begin r_op = a_word;    s_op = b_word;    end
         SRC_Z_Q: begin r_op = ZERO_WORD; s_op = q_word;    end
         SRC_Z_B: begin r_op = ZERO_WORD; s_op = b_word;    end
         SRC_Z_A: begin r_op = ZERO_WORD; s_op = a_word;    end
         SRC_D_A: begin r_op = d_word;    s_op = a_word;    end
         SRC_D_Q: begin r_op = d_word;    s_op = q_word;    end
         default: begin r_op = d_word;    s_op = ZERO_WORD; end
      endcase
   end

   // R1: the zero-substituting codes must present a zero operand
   always_comb begin
      if (src == SRC_D_Z) begin
         assert_zero_s_R1: assert (s_op == ZERO_WORD)
            else $error("R1 source 7 S operand not zero");
      end
      if (src == SRC_Z_Q || src == SRC_Z_B || src == SRC_Z_A) begin
         assert_zero_r_R1: assert (r_op == ZERO_WORD)
            else $error("R1 zero-R source gave nonzero R");
      end
   end

endmodule

// File: rtl/slice_alu_adder.sv
module slice_alu_adder
   import slice_alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = ADDER_GROUPED,
   parameter int GROUP       = 4
) (
   input  logic [WIDTH-1:0] x_in,
   input  logic [WIDTH-1:0] y_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             ovf
);

   localparam int NGROUPS = WIDTH / GROUP;

   logic [WIDTH-1:0] gen_b;
   logic [WIDTH-1:0] prop_b;
   logic [WIDTH:0]   carry;

   assign gen_b  = x_in & y_in;
   assign prop_b = x_in ^ y_in;

   generate
      if (ADDER_STYLE == ADDER_RIPPLE) begin : g_ripple
         always_comb begin
            carry[0] = c_in;
            for (int i = 0; i < WIDTH; i++) begin
               carry[i+1] = gen_b[i] | (prop_b[i] & carry[i]);
            end
         end
      end else begin : g_grouped
         always_comb begin
            logic grp_g;
            logic grp_p;
            carry[0] = c_in;
            for (int g = 0; g < NGROUPS; g++) begin
               grp_g = 1'b0;
               grp_p = 1'b1;
               for (int k = 0; k < GROUP; k++) begin
                  grp_g = gen_b[g*GROUP+k] | (prop_b[g*GROUP+k] & grp_g);
                  grp_p = grp_p & prop_b[g*GROUP+k];
               end
               for (int k = 0; k < GROUP-1; k++) begin
                  carry[g*GROUP+k+1] = gen_b[g*GROUP+k]
                                     | (prop_b[g*GROUP+k] & carry[g*GROUP+k]);
               end
               carry[(g+1)*GROUP] = grp_g | (grp_p & carry[g*GROUP]);
            end
         end
      end
   endgenerate

   assign sum   = prop_b ^ carry[WIDTH-1:0];
   assign c_out = carry[WIDTH];
   assign ovf   = carry[WIDTH] ^ carry[WIDTH-1];

   // R9: overflow only when operand signs agree and the sum sign differs
   // R10: a fully propagating pair hands the input carry to the output
   always_comb begin
      if (ovf) begin
         assert_no_overflow_R9: assert ((x_in[WIDTH-1] == y_in[WIDTH-1]) &&
                                        (sum[WIDTH-1] != x_in[WIDTH-1]))
            else $error("R9 overflow without sign flip");
      end
      if (x_in == ~y_in) begin
         assert_carry_pass_R10: assert (c_out == c_in)
            else $error("R10 propagate chain broke carry");
      end
   end

endmodule

// File: rtl/slice_alu_logic.sv
module slice_alu_logic
   import slice_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  fn_sel_e          fn,
   input  logic [WIDTH-1:0] r_op,
   input  logic [WIDTH-1:0] s_op,
   output logic [WIDTH-1:0] lg_out
);

   always_comb begin
      unique case (fn)
         FN_OR:   lg_out = r_op | s_op;
         FN_AND:  lg_out = r_op & s_op;
         FN_ANDN: lg_out = ~r_op & s_op;
         FN_XOR:  lg_out = r_op ^ s_op;
         FN_XNOR: lg_out = ~(r_op ^ s_op);
         default: lg_out = '0;
      endcase
   end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
   import slice_alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = ADDER_GROUPED,
   parameter int GROUP       = 4
) (
   input  logic [2:0]       src_sel,
   input  logic [2:0]       fn_sel,
   input  logic             carry_in,
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   input  logic [WIDTH-1:0] d_val,
   input  logic [WIDTH-1:0] q_val,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             overflow,
   output logic             sign,
   output logic             zero
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("slice_alu: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != ADDER_RIPPLE && ADDER_STYLE != ADDER_GROUPED) begin : g_bad_style
         $error("slice_alu: unknown ADDER_STYLE");
      end
      if (ADDER_STYLE == ADDER_GROUPED && (GROUP < 1 || (WIDTH % GROUP) != 0)) begin : g_bad_group
         $error("slice_alu: WIDTH must be a multiple of GROUP");
      end
   endgenerate

   src_sel_e         src;
   fn_sel_e          fn;
   logic             arith;
   logic [WIDTH-1:0] r_op, s_op;
   logic [WIDTH-1:0] add_x, add_y, add_sum, lg_out;
   logic             add_cout, add_ovf;

   assign src   = src_sel_e'(src_sel);
   assign fn    = fn_sel_e'(fn_sel);
   assign arith = fn_is_arith(fn);

   slice_alu_operands #(.WIDTH(WIDTH)) u_operands (
      .src    (src),
      .a_word (a_val),
      .b_word (b_val),
      .d_word (d_val),
      .q_word (q_val),
      .r_op   (r_op),
      .s_op   (s_op)
   );

   assign add_x = (fn == FN_SUB_SR) ? ~r_op : r_op;
   assign add_y = (fn == FN_SUB_RS) ? ~s_op : s_op;

   slice_alu_adder #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE),
      .GROUP       (GROUP)
   ) u_adder (
      .x_in  (add_x),
      .y_in  (add_y),
      .c_in  (carry_in),
      .sum   (add_sum),
      .c_out (add_cout),
      .ovf   (add_ovf)
   );

   slice_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .fn     (fn),
      .r_op   (r_op),
      .s_op   (s_op),
      .lg_out (lg_out)
   );

   assign result    = arith ? add_sum : lg_out;
   assign carry_out = arith & add_cout;
   assign overflow  = arith & add_ovf;
   assign sign      = result[MSB];
   assign zero      = ~|result;

   // R11: logic codes leave both arithmetic flags low
   // R7: a zero result can never carry a set sign bit
   always_comb begin
      if (fn_sel >= 3'd3) begin
         assert_logic_flags_R11: assert (!carry_out && !overflow)
            else $error("R11 arithmetic flag set in logic mode");
      end
      if (zero) begin
         assert_sign_zero_R7: assert (!sign)
            else $error("R7 sign set on zero result");
      end
   end

endmodule

// File: tb/slice_alu_test.sv
`timescale 1ns/1ps
module slice_alu_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  src_sel = '0;
   logic [2:0]  fn_sel = '0;
   logic        carry_in = 1'b0;
   logic [31:0] a_val = '0, b_val = '0, d_val = '0, q_val = '0;
   logic [31:0] result;
   logic        carry_out, overflow, sign, zero;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   slice_alu #(.WIDTH(32)) uut (
      .src_sel (src_sel), .fn_sel (fn_sel), .carry_in (carry_in),
      .a_val (a_val), .b_val (b_val), .d_val (d_val), .q_val (q_val),
      .result (result), .carry_out (carry_out), .overflow (overflow),
      .sign (sign), .zero (zero)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] s, input logic [2:0] f, input logic cn,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] d, input logic [31:0] q);
      @(negedge clk);
      src_sel = s; fn_sel = f; carry_in = cn;
      a_val = a; b_val = b; d_val = d; q_val = q;
      #1;
   endtask

   task automatic model(input logic [2:0] s, input logic [2:0] f, input logic cn,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] d, input logic [31:0] q,
                        output logic [31:0] fo, output logic co, output logic ov);
      logic [31:0] r, sv, x, y;
      logic [32:0] wide;
      case (s)
         3'd0: begin r = a; sv = q; end
         3'd1: begin r = a; sv = b; end
         3'd2: begin r = 0; sv = q; end
         3'd3: begin r = 0; sv = b; end
         3'd4: begin r = 0; sv = a; end
         3'd5: begin r = d; sv = a; end
         3'd6: begin r = d; sv = q; end
         default: begin r = d; sv = 0; end
      endcase
      co = 1'b0; ov = 1'b0;
      if (f <= 3'd2) begin
         x = (f == 3'd1) ? ~r : r;
         y = (f == 3'd2) ? ~sv : sv;
         wide = {1'b0, x} + {1'b0, y} + {32'd0, cn};
         fo = wide[31:0];
         co = wide[32];
         ov = (x[31] == y[31]) && (fo[31] != x[31]);
      end else begin
         case (f)
            3'd3: fo = r | sv;
            3'd4: fo = r & sv;
            3'd5: fo = ~r & sv;
            3'd6: fo = r ^ sv;
            default: fo = ~(r ^ sv);
         endcase
      end
   endtask

   task automatic chk_flags(input string tag, input logic [31:0] exp_f,
                            input logic exp_co, input logic exp_ov);
      chk({tag, " result"}, result, exp_f);
      chk({tag, " carry_out R10"}, {31'd0, carry_out}, {31'd0, exp_co});
      chk({tag, " overflow R9"}, {31'd0, overflow}, {31'd0, exp_ov});
      chk({tag, " sign R7"}, {31'd0, sign}, {31'd0, exp_f[31]});
      chk({tag, " zero R8"}, {31'd0, zero}, {31'd0, (exp_f == 32'd0)});
   endtask

   task automatic t_idle;
      apply(3'd0, 3'd0, 1'b0, 0, 0, 0, 0);
      chk("idle R8 zero", {31'd0, zero}, 32'd1);
      chk("idle R2 result", result, 32'd0);
   endtask

   task automatic t_sources;
      logic [31:0] exp_tab [8];
      exp_tab[0] = 32'h1001; exp_tab[1] = 32'h0011; exp_tab[2] = 32'h1000;
      exp_tab[3] = 32'h0010; exp_tab[4] = 32'h0001; exp_tab[5] = 32'h0101;
      exp_tab[6] = 32'h1100; exp_tab[7] = 32'h0100;
      for (int i = 0; i < 8; i++) begin
         apply(i[2:0], 3'd0, 1'b0, 32'h1, 32'h10, 32'h100, 32'h1000);
         chk($sformatf("R1 source %0d add", i), result, exp_tab[i]);
         apply(i[2:0], 3'd3, 1'b0, 32'h1, 32'h10, 32'h100, 32'h1000);
         chk($sformatf("R1 source %0d or", i), result, exp_tab[i]);
      end
   endtask

   task automatic t_arith;
      apply(3'd1, 3'd0, 1'b1, 32'd5, 32'd7, 0, 0);
      chk_flags("R2 add with carry", 32'd13, 1'b0, 1'b0);
      apply(3'd7, 3'd1, 1'b0, 0, 0, 32'd5, 0);
      chk_flags("R3 minus D minus 1", 32'hFFFF_FFFA, 1'b0, 1'b0);
      apply(3'd7, 3'd1, 1'b1, 0, 0, 32'd5, 0);
      chk_flags("R3 minus D", 32'hFFFF_FFFB, 1'b0, 1'b0);
      apply(3'd1, 3'd1, 1'b1, 32'd3, 32'd10, 0, 0);
      chk_flags("R3 B minus A", 32'd7, 1'b1, 1'b0);
      apply(3'd1, 3'd2, 1'b1, 32'd10, 32'd3, 0, 0);
      chk_flags("R4 A minus B", 32'd7, 1'b1, 1'b0);
      apply(3'd1, 3'd2, 1'b0, 32'd3, 32'd10, 0, 0);
      chk_flags("R4 borrow", 32'hFFFF_FFF8, 1'b0, 1'b0);
   endtask

   task automatic t_limits;
      apply(3'd1, 3'd0, 1'b0, 32'h7FFF_FFFF, 32'd1, 0, 0);
      chk_flags("R9 signed overflow add", 32'h8000_0000, 1'b0, 1'b1);
      apply(3'd1, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'd1, 0, 0);
      chk_flags("R10 unsigned wrap", 32'd0, 1'b1, 1'b0);
      apply(3'd1, 3'd2, 1'b1, 32'h8000_0000, 32'd1, 0, 0);
      chk_flags("R9 signed overflow sub", 32'h7FFF_FFFF, 1'b1, 1'b1);
      apply(3'd0, 3'd0, 1'b1, 32'hFFFF_FFFF, 0, 0, 32'd0);
      chk_flags("R10 carry through", 32'd0, 1'b1, 1'b0);
   endtask

   task automatic t_logic;
      logic [31:0] exp_tab [8];
      exp_tab[3] = 32'hFFF0_0FFF; exp_tab[4] = 32'hF000_000F;
      exp_tab[5] = 32'h0F00_0F00; exp_tab[6] = 32'h0FF0_0FF0;
      exp_tab[7] = 32'hF00F_F00F;
      for (int f = 3; f < 8; f++) begin
         for (int c = 0; c < 2; c++) begin
            apply(3'd1, f[2:0], c[0], 32'hF0F0_00FF, 32'hFF00_0F0F, 0, 0);
            chk_flags($sformatf("R5 R6 R11 fn %0d cin %0d", f, c), exp_tab[f], 1'b0, 1'b0);
         end
      end
      apply(3'd4, 3'd4, 1'b1, 32'hFFFF_FFFF, 0, 0, 0);
      chk_flags("R8 zero from AND", 32'd0, 1'b0, 1'b0);
   endtask

   task automatic t_sweep;
      logic [31:0] lf, ea, eb, ed, eq, ef;
      logic eco, eov;
      lf = 32'hACE1_1234;
      for (int n = 0; n < 400; n++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         ea = lf;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         eb = (n % 5 == 0) ? ~ea : lf;
         ed = lf ^ 32'h8000_0001;
         eq = {lf[15:0], lf[31:16]};
         model(ea[2:0], ea[5:3], ea[8], ea, eb, ed, eq, ef, eco, eov);
         apply(ea[2:0], ea[5:3], ea[8], ea, eb, ed, eq);
         chk_flags("sweep R1 R2 R3 R4 R5", ef, eco, eov);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_sources();
      t_arith();
      t_limits();
      t_logic();
      t_sweep();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule